// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block behaves as a 128-byte serial EEPROM on a two-wire I2C bus, acting only as a target. A system clock oversamples SCL and SDA, so the block finds start and stop conditions and data edges itself. It pulls SDA low through a single open-drain enable output. The bus address is a fixed 4-bit prefix, binary 1010, followed by three strap inputs. Up to eight such targets can share one bus.

A write transaction carries a word address and then data bytes. The data bytes are collected in an 8-byte page buffer and reach the array only when the host ends the transaction with a stop. The pointer moves within the current page, so a long write wraps back to the start of that page. A committed write starts an internal busy period whose length is a parameter in clock cycles. During that period the target does not acknowledge its address, so the host polls until it does. Reads start at the current pointer and stream bytes out until the host answers a byte with a NACK. A write-protect input keeps the array unchanged.

Top module: `eep_target`

## Requirements
- R1: The target acknowledges a control byte only when its upper seven bits equal 1010 followed by `strap_i[2:0]`; bit 0 is the direction (0 write, 1 read). On a mismatch it sends no acknowledge and leaves SDA alone until the next start.
- R2: A start (SDA falling while SCL is high) restarts control-byte reception at any point, including as a repeated start. A stop (SDA rising while SCL is high) returns the target to idle.
- R3: In a write-direction transaction, the byte after the control byte sets the pointer to its low seven bits; bit 7 is ignored. The target acknowledges this byte.
- R4: Each data byte written is acknowledged and stored at the pointer. The pointer then advances in bits 2:0 only, so a ten-byte write starting at page offset 6 leaves the last two bytes at offsets 6 and 7.
- R5: Buffered bytes reach the array at a stop. Bits of an incomplete byte before the stop are dropped. A start before any stop discards all buffered bytes.
- R6: When `wp_i` is high at the stop, the array keeps its contents and no busy period starts. The address and data bytes are still acknowledged.
- R7: After a committed write, control bytes are not acknowledged for BUSY_CYCLES clocks. After that, they are acknowledged again.
- R8: A read returns the byte at the pointer, most significant bit first, and the pointer then advances by one. Reads wrap from 0x7F to 0x00, and a read with no address phase continues from the current pointer.
- R9: When the host NACKs a read byte, the target releases SDA and drives nothing until the next start or stop.
- R10: The target only pulls SDA low, and only in its own acknowledge slots and read data bits. After reset SDA is released, the pointer is 0x00 and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_oe | output | 1 | High to pull SDA low (open drain) |
| strap_i | input | 3 | Low three bits of the bus address |
| wp_i | input | 1 | Write protect, high blocks array updates |

## Verification
The assertions assume that SCL and SDA each hold a level for longer than the synchronizer delay. They also assume that SDA moves while SCL is high only to form a start or a stop, and that `wp_i` is steady around each stop. The bench keeps within this. It holds each quarter of a bit period for eight clocks and changes SDA only in the middle of the SCL-low phase, except inside its start and stop tasks. It changes `wp_i` only while the bus is idle. Under these conditions every SCL edge the target sees corresponds to one host edge, and the open-drain line is modelled as a wired AND of the host and target drives.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CTRL,
    S_ACKC,
    S_ADDR,
    S_ACKA,
    S_WDATA,
    S_ACKW,
    S_RDATA,
    S_RACK
  } tgt_state_e;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d, scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_q     = scl_sh[STAGES-1];
  assign sda_q     = sda_sh[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer #(
  parameter int CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (start)       cnt <= CW'(CYCLES);
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);

  p_busy_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int WORDS = 128,
  parameter int PAGE  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wp_i,
  input  logic                     buf_clr,
  input  logic                     buf_wr,
  input  logic [$clog2(PAGE)-1:0]  buf_ofs,
  input  logic [$clog2(WORDS)-$clog2(PAGE)-1:0] buf_page,
  input  logic [7:0]               buf_data,
  input  logic                     commit,
  input  logic [$clog2(WORDS)-1:0] rd_addr,
  output logic [7:0]               rd_data,
  output logic                     committed
);
  localparam int AW = $clog2(WORDS);
  localparam int OW = $clog2(PAGE);
  localparam int PW = AW - OW;

  logic [7:0]    mem  [WORDS];
  logic [7:0]    pbuf [PAGE];
  logic [PAGE-1:0] pvalid;
  logic [PW-1:0] page_q;
  logic [AW-1:0] slot_addr [PAGE];
  logic          any_valid;

  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    assign slot_addr[g] = {page_q, OW'(g)};
  end

  assign any_valid = |pvalid;
  assign committed = commit & any_valid & ~wp_i;
  assign rd_data   = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= 8'hFF;
    end else if (committed) begin
      for (int i = 0; i < PAGE; i++)
        if (pvalid[i]) mem[slot_addr[i]] <= pbuf[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pvalid <= '0;
      page_q <= '0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
    end else if (buf_clr || commit) begin
      pvalid <= '0;
    end else if (buf_wr) begin
      pbuf[buf_ofs]   <= buf_data;
      pvalid[buf_ofs] <= 1'b1;
      page_q          <= buf_page;
    end
  end

  p_wp_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_i && $past(wp_i) && $stable(rd_addr)) |-> $stable(rd_data));
endmodule

// File: rtl/eep_target.sv
module eep_target #(
  parameter int WORDS       = 128,
  parameter int PAGE        = 8,
  parameter int BUSY_CYCLES = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  import eep_pkg::*;

  localparam int AW = $clog2(WORDS);
  localparam int OW = $clog2(PAGE);
  localparam logic [OW-1:0] OFS_ONE = OW'(1);
  localparam logic [AW-1:0] PTR_ONE = AW'(1);

  tgt_state_e state;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [AW-1:0] ptr;
  logic          rd_dir, host_ack;

  logic sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic busy, committed, buf_wr, byte_end, ctrl_match;
  logic [7:0] rd_data;

  eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_store #(.WORDS(WORDS), .PAGE(PAGE)) u_store (
    .clk(clk), .rst_n(rst_n), .wp_i(wp_i),
    .buf_clr(start_det), .buf_wr(buf_wr),
    .buf_ofs(ptr[OW-1:0]), .buf_page(ptr[AW-1:OW]), .buf_data(shreg),
    .commit(stop_det), .rd_addr(ptr), .rd_data(rd_data),
    .committed(committed)
  );

  eep_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(committed), .busy(busy)
  );

  assign byte_end   = scl_fall && (bitcnt == 4'd8);
  assign ctrl_match = (shreg[7:4] == DEV_PREFIX) && (shreg[3:1] == strap_i);
  assign buf_wr     = (state == S_WDATA) && byte_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      ptr      <= '0;
      rd_dir   <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (start_det) begin
      state  <= S_CTRL;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: ;
        S_CTRL, S_ADDR, S_WDATA: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_q};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_end) begin
            bitcnt <= '0;
            if (state == S_CTRL) begin
              if (ctrl_match && !busy) begin
                rd_dir <= shreg[0];
                sda_oe <= 1'b1;
                state  <= S_ACKC;
              end else begin
                state  <= S_IDLE;
              end
            end else if (state == S_ADDR) begin
              ptr    <= shreg[AW-1:0];
              sda_oe <= 1'b1;
              state  <= S_ACKA;
            end else begin
              ptr    <= {ptr[AW-1:OW], ptr[OW-1:0] + OFS_ONE};
              sda_oe <= 1'b1;
              state  <= S_ACKW;
            end
          end
        end
        S_ACKC: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rd_dir) begin
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
              state  <= S_RDATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_ADDR;
            end
          end
        end
        S_ACKA, S_ACKW: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= S_WDATA;
          end
        end
        S_RDATA: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              ptr    <= ptr + PTR_ONE;
              bitcnt <= '0;
              state  <= S_RACK;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            host_ack <= ~sda_q;
          end else if (scl_fall) begin
            if (host_ack) begin
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
              state  <= S_RDATA;
            end else begin
              state  <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_oe_owner_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state inside {S_ACKC, S_ACKA, S_ACKW, S_RDATA}));

  p_busy_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACKC) |-> !busy);

  p_page_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |=> (ptr[AW-1:OW] == $past(ptr[AW-1:OW])));

  p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == S_IDLE) && !sda_oe);

  p_start_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == S_CTRL) && !sda_oe);

  p_nack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RACK && !host_ack && scl_fall && !start_det && !stop_det)
      |=> (state == S_IDLE) && !sda_oe);
endmodule

// File: tb/eep_target_test.sv
`timescale 1ns/1ps
module eep_target_test;
  localparam int BUSY = 600;
  localparam int Q    = 8;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_h = 1'b1, wp = 1'b0, drv_ok = 1'b0;
  logic sda_oe, sda_line;
  int vec = 0, bad = 0, cycles = 0;
  int mem_m [128];
  int ptr_m = 0;

  always #2 clk = ~clk;
  assign sda_line = sda_h & ~sda_oe;

  eep_target #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap_i(STRAP), .wp_i(wp)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R10/R9: target must not pull SDA outside its own slots, checked every clock
  always @(posedge clk) begin
    #1;
    cycles++;
    if (!drv_ok) begin
      vec++;
      if (sda_oe !== 1'b0) begin
        bad++;
        $display("FAIL R10 R9 drive outside slot actual=%0h expected=0", sda_oe);
      end
    end
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_xfer(input bit tgt, input bit hb, output bit got);
    if (tgt) drv_ok = 1'b1;
    wt(Q);
    if (!tgt) drv_ok = 1'b0;
    sda_h = tgt ? 1'b1 : hb;
    wt(Q);
    scl = 1'b1;
    wt(Q);
    got = sda_line;
    wt(Q);
    scl = 1'b0;
  endtask

  task automatic bus_start();
    wt(Q); drv_ok = 1'b0; sda_h = 1'b1;
    wt(Q); scl = 1'b1;
    wt(Q); sda_h = 1'b0;
    wt(Q); scl = 1'b0;
  endtask

  task automatic bus_stop();
    wt(Q); drv_ok = 1'b0; sda_h = 1'b0;
    wt(Q); scl = 1'b1;
    wt(Q); sda_h = 1'b1;
    wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit g;
    for (int i = 7; i >= 0; i--) bit_xfer(1'b0, b[i], g);
    bit_xfer(1'b1, 1'b1, g);
    ack = !g;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit more);
    bit g;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, 1'b1, g);
      b[i] = g;
    end
    bit_xfer(1'b0, !more, g);
  endtask

  function automatic logic [7:0] ctl(input bit rd);
    return {4'b1010, STRAP, rd};
  endfunction

  // write n bytes (base + k*step) at addr; model commits at stop unless wp
  task automatic write_txn(input int addr, input int n, input int base, input int step,
                           input string req);
    bit ack;
    int p, d;
    int pend_a [16];
    int pend_d [16];
    bus_start();
    send_byte(ctl(1'b0), ack); chk(ack, "R1 write ctrl ack", ack, 1);
    send_byte(addr[7:0], ack); chk(ack, "R3 word addr ack", ack, 1);
    p = addr & 'h7F;
    for (int k = 0; k < n; k++) begin
      d = (base + k * step) & 'hFF;
      send_byte(d[7:0], ack); chk(ack, req, ack, 1);
      pend_a[k] = p; pend_d[k] = d;
      p = (p & 'h78) | ((p + 1) & 7);
    end
    bus_stop();
    if (!wp) for (int k = 0; k < n; k++) mem_m[pend_a[k]] = pend_d[k];
    ptr_m = p;
  endtask

  task automatic poll_ready(output int polls);
    bit ack;
    polls = 0;
    for (int t = 0; t < 50; t++) begin
      bus_start();
      send_byte(ctl(1'b0), ack);
      bus_stop();
      if (ack) break;
      polls++;
    end
  endtask

  // addr < 0: current-address read
  task automatic read_txn(input int addr, input int n, input string req);
    bit ack;
    logic [7:0] b;
    if (addr >= 0) begin
      bus_start();
      send_byte(ctl(1'b0), ack); chk(ack, "R1 ctrl ack", ack, 1);
      send_byte(addr[7:0], ack); chk(ack, "R3 addr ack", ack, 1);
      ptr_m = addr & 'h7F;
    end
    bus_start();
    send_byte(ctl(1'b1), ack); chk(ack, "R1 read ctrl ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(b, k < n - 1);
      chk(b == mem_m[ptr_m][7:0], req, b, mem_m[ptr_m]);
      ptr_m = (ptr_m + 1) & 'h7F;
    end
    bus_stop();
  endtask

  initial begin
    bit ack;
    bit g;
    int polls;
    logic [7:0] b;
    for (int i = 0; i < 128; i++) mem_m[i] = 'hFF;
    wt(5);
    rst_n = 1'b1;
    wt(3);
    chk(sda_oe == 1'b0, "R10 reset release", sda_oe, 0);
    read_txn(-1, 1, "R10 reset contents at ptr 0");

    // R1 mismatch: strap differs, no ack, no drive on next byte
    bus_start();
    send_byte({4'b1010, 3'b100, 1'b0}, ack); chk(!ack, "R1 wrong strap nack", ack, 0);
    send_byte(8'h00, ack); chk(!ack, "R1 ignore after mismatch", ack, 0);
    bus_stop();
    send_byte(8'h00, ack); chk(!ack, "R2 no ack without start", ack, 0);
    bus_stop();

    // R4/R7 simple write and busy polling
    write_txn('h00, 1, 'h5A, 0, "R4 data ack");
    poll_ready(polls);
    chk(polls >= 1, "R7 busy nack after write", polls, 1);
    chk(polls < 50, "R7 ack after busy", polls, 49);
    write_txn('h10, 3, 'hA1, 'h11, "R4 data ack");
    poll_ready(polls);
    chk(polls >= 1, "R7 busy nack second write", polls, 1);
    read_txn('h10, 3, "R8 read back");
    read_txn('h90, 2, "R3 addr msb ignored");

    // R4 page wrap: ten bytes from 0x1E
    write_txn('h1E, 10, 'h30, 1, "R4 wrap data ack");
    poll_ready(polls);
    read_txn('h17, 10, "R4 page wrap contents");

    // R6 write protect
    wp = 1'b1;
    write_txn('h40, 2, 'h12, 1, "R6 ack while protected");
    poll_ready(polls);
    chk(polls == 0, "R6 no busy while protected", polls, 0);
    wp = 1'b0;
    read_txn('h40, 2, "R6 array unchanged");

    // R5 partial byte before stop
    bus_start();
    send_byte(ctl(1'b0), ack);
    send_byte(8'h50, ack);
    send_byte(8'h11, ack); chk(ack, "R5 byte ack", ack, 1);
    send_byte(8'h22, ack); chk(ack, "R5 byte ack", ack, 1);
    for (int i = 0; i < 4; i++) bit_xfer(1'b0, 1'b0, g);
    bus_stop();
    mem_m['h50] = 'h11; mem_m['h51] = 'h22; ptr_m = 'h52;
    poll_ready(polls);
    chk(polls >= 1, "R7 busy after partial stop", polls, 1);
    read_txn('h50, 3, "R5 partial byte dropped");

    // R5 repeated start discards buffer; R2 repeated start accepted
    bus_start();
    send_byte(ctl(1'b0), ack);
    send_byte(8'h60, ack);
    send_byte(8'h77, ack);
    ptr_m = 'h61;
    bus_start();
    send_byte(ctl(1'b1), ack); chk(ack, "R2 repeated start read ack", ack, 1);
    recv_byte(b, 1'b0);
    chk(b == mem_m[ptr_m][7:0], "R8 read after restart", b, mem_m[ptr_m]);
    ptr_m = (ptr_m + 1) & 'h7F;
    bus_stop();
    poll_ready(polls);
    chk(polls == 0, "R5 nothing committed no busy", polls, 0);
    read_txn('h60, 1, "R5 discarded byte absent");

    // R8 wrap across array end, then current-address read
    read_txn('h7E, 3, "R8 wrap 7F to 00");
    read_txn(-1, 1, "R8 current address read");

    // R9: after host NACK the target stays off the bus
    bus_start();
    send_byte(ctl(1'b1), ack);
    recv_byte(b, 1'b0);
    chk(b == mem_m[ptr_m][7:0], "R8 read before nack", b, mem_m[ptr_m]);
    ptr_m = (ptr_m + 1) & 'h7F;
    for (int i = 0; i < 9; i++) begin
      bit_xfer(1'b0, 1'b1, g);
      chk(g == 1'b1, "R9 released after nack", g, 1);
    end
    bus_stop();

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule